// File: doc/BRIEF.md
# Round-Robin Execution Unit Picker

This block keeps track of the free execution units behind a fixed set of processor resources and names one specific unit whenever an operation asks for a resource. Each leaf resource owns `UNITS` units, and each unit is one bit of a one-hot mask. One further resource is a group whose members are the leaf resources. A request that names the group first picks a member leaf and then picks a unit inside that leaf. Every resource holds three masks:

- an availability mask of its free units;
- a rotation mask that spreads grants fairly over its units;
- for the group, a set of members that were dropped from the rotation and whose reload is deferred.

A requester presents a resource index on the select port. The block answers in the same cycle with the chosen (leaf, unit) pair. When the handshake completes, that unit counts as busy. The use port marks a unit busy without asking for a grant. The release port frees a unit again. Whenever a leaf runs out of free units or gets one back, the group that contains it is updated as well.

Top module: `rr_unit_picker`

## Requirements
- R1: After reset every resource reports a free unit on `res_ready` (bit i = resource i, leaf resources 0..NUM_RES-1, the group at index NUM_RES). The first grant on any leaf is its highest unit (unit mask bit UNITS-1).
- R2: `sel_ready` is high only while neither `use_valid` nor `rel_valid` is high and the addressed resource has at least one free unit.
- R3: The candidate is the highest set bit of the rotation mask. A candidate that is not free is dropped from the rotation and the next lower bit is tried. When the rotation runs empty it reloads to all units. So grants on a leaf run from unit UNITS-1 down to unit 0 and then wrap.
- R4: A completed select handshake marks the granted unit busy. That unit is not granted again until it is released.
- R5: A select on the group index first picks a member leaf through the group's own rotation (bit i = leaf i, highest first). It then picks a unit through that leaf's rotation, and both rotations advance.
- R6: When a leaf loses its last free unit, its bit is cleared in the group's availability mask and removed from the group's rotation. When all leaves are busy, the group reports no free unit.
- R7: If the removed leaf bit is above the group's current candidate, it is recorded in the deferred set. When a removal empties the group rotation, the rotation reloads to all members XOR the deferred set, and the deferred set clears.
- R8: A release makes the named unit free again. The group's availability bit for that leaf is restored only if the leaf had no free unit just before the release.
- R9: When use and release arrive in the same cycle, the release is applied and the use is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Select request present |
| sel_res | input | RW | Resource index to select from (NUM_RES = group) |
| sel_ready | output | 1 | Select can be accepted this cycle |
| sel_grant_res | output | RW | Leaf resource of the chosen unit |
| sel_grant_unit | output | UNITS | One-hot chosen unit |
| use_valid | input | 1 | Mark a unit busy |
| use_res | input | RW | Leaf index for the use |
| use_unit | input | UNITS | One-hot unit for the use |
| rel_valid | input | 1 | Free a unit |
| rel_res | input | RW | Leaf index for the release |
| rel_unit | input | UNITS | One-hot unit for the release |
| res_ready | output | NUM_RES+1 | Per-resource flag: at least one free unit |

## Verification
The embedded properties check on every cycle the following:

- a grant is one-hot and names a free unit;
- a granted unit is busy in the next cycle;
- `sel_ready` never rises for a resource without free units;
- each group availability bit agrees with the free state of its leaf.

Only the directed scenarios can show the following:

- the order in which grants rotate and wrap;
- the skipping of busy candidates;
- the effect of the deferred set on which leaf the group picks after its rotation reloads;
- the dropping of a use that collides with a release.

// File: rtl/rr_pkg.sv
package rr_pkg;

  // One-hot mask of the highest set bit (zero in, zero out).
  function automatic logic [31:0] msb_of(input logic [31:0] v);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = 32'd1 << i;
    end
    return r;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] seq,
  input  logic [W-1:0] avail,
  input  logic [W-1:0] size_m,
  output logic [W-1:0] cand,
  output logic [W-1:0] seq_skip
);
  import rr_pkg::*;

  logic [W-1:0]  n;
  logic [W-1:0]  c;
  logic [31:0]   c32;
  logic          found;

  always_comb begin
    n     = (seq == '0) ? size_m : seq;
    c     = '0;
    c32   = '0;
    found = 1'b0;
    for (int i = 0; i <= W; i++) begin
      if (!found) begin
        c32 = msb_of(32'(n));
        c   = c32[W-1:0];
        if ((c & avail) != '0) begin
          found = 1'b1;
        end else begin
          n = n & ~c;
          if (n == '0) n = size_m;
        end
      end
    end
    cand     = found ? c : '0;
    seq_skip = n;
  end

endmodule

// File: rtl/rr_res_reg.sv
module rr_res_reg #(
  parameter int           W      = 4,
  parameter logic [W-1:0] INIT_M = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] avail_d,
  input  logic [W-1:0] seq_d,
  input  logic [W-1:0] def_d,
  output logic [W-1:0] avail_q,
  output logic [W-1:0] seq_q,
  output logic [W-1:0] def_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= INIT_M;
      seq_q   <= INIT_M;
      def_q   <= '0;
    end else if (en) begin
      avail_q <= avail_d;
      seq_q   <= seq_d;
      def_q   <= def_d;
    end
  end

endmodule

// File: rtl/rr_unit_picker.sv
module rr_unit_picker #(
  parameter int NUM_RES = 3,
  parameter int UNITS   = 4,
  parameter int RW      = $clog2(NUM_RES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_valid,
  input  logic [RW-1:0]        sel_res,
  output logic                 sel_ready,
  output logic [RW-1:0]        sel_grant_res,
  output logic [UNITS-1:0]     sel_grant_unit,
  input  logic                 use_valid,
  input  logic [RW-1:0]        use_res,
  input  logic [UNITS-1:0]     use_unit,
  input  logic                 rel_valid,
  input  logic [RW-1:0]        rel_res,
  input  logic [UNITS-1:0]     rel_unit,
  output logic [NUM_RES:0]     res_ready
);
  import rr_pkg::*;

  localparam int           NR        = NUM_RES + 1;
  localparam int           GID       = NUM_RES;
  localparam int           W         = (UNITS > NUM_RES) ? UNITS : NUM_RES;
  localparam logic [W-1:0] LEAF_SIZE = W'((64'd1 << UNITS) - 64'd1);
  localparam logic [W-1:0] GRP_SIZE  = W'((64'd1 << NUM_RES) - 64'd1);

  logic [W-1:0] size_m  [NR];
  logic [W-1:0] avail_q [NR];
  logic [W-1:0] seq_q   [NR];
  logic [W-1:0] def_q   [NR];
  logic [W-1:0] avail_d [NR];
  logic [W-1:0] seq_d   [NR];
  logic [W-1:0] def_d   [NR];
  logic [W-1:0] cand    [NR];
  logic [W-1:0] skip    [NR];
  logic         upd_en;

  // Per-resource state and unit pick
  for (genvar r = 0; r < NR; r++) begin : g_res
    localparam logic [W-1:0] SZ = (r == GID) ? GRP_SIZE : LEAF_SIZE;
    assign size_m[r] = SZ;

    rr_res_reg #(.W(W), .INIT_M(SZ)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (upd_en),
      .avail_d (avail_d[r]),
      .seq_d   (seq_d[r]),
      .def_d   (def_d[r]),
      .avail_q (avail_q[r]),
      .seq_q   (seq_q[r]),
      .def_q   (def_q[r])
    );

    rr_pick #(.W(W)) u_pick (
      .seq      (seq_q[r]),
      .avail    (avail_q[r]),
      .size_m   (size_m[r]),
      .cand     (cand[r]),
      .seq_skip (skip[r])
    );

    assign res_ready[r] = |avail_q[r];
  end

  // Select path
  logic          tgt_grp;
  logic          sel_in_rng;
  logic [RW-1:0] gidx;
  logic [W-1:0]  gunit_w;
  logic          accept;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NUM_RES; i++) begin
      if (cand[GID][i]) gidx = RW'(i);
    end
  end

  assign sel_in_rng     = (32'(sel_res) <= GID);
  assign tgt_grp        = (32'(sel_res) == GID);
  assign sel_ready      = sel_in_rng && !use_valid && !rel_valid && res_ready[sel_res];
  assign sel_grant_res  = tgt_grp ? gidx : sel_res;
  assign gunit_w        = cand[sel_grant_res];
  assign sel_grant_unit = gunit_w[UNITS-1:0];
  assign accept         = sel_valid && sel_ready;

  // Use / release events
  logic          u_en;
  logic [RW-1:0] u_res;
  logic [W-1:0]  u_unit;

  assign u_en   = accept || (use_valid && !rel_valid);
  assign u_res  = accept ? sel_grant_res : use_res;
  assign u_unit = accept ? gunit_w : W'(use_unit);
  assign upd_en = u_en || rel_valid;

  // Next-state logic
  always_comb begin
    logic [W-1:0] nv;
    logic [W-1:0] bitm;
    logic [W-1:0] base;
    logic [31:0]  top32;
    for (int r = 0; r < NR; r++) begin
      avail_d[r] = avail_q[r];
      seq_d[r]   = seq_q[r];
      def_d[r]   = def_q[r];
    end
    nv    = '0;
    bitm  = '0;
    base  = '0;
    top32 = '0;

    if (accept) begin
      nv = skip[sel_grant_res] & ~gunit_w;
      seq_d[sel_grant_res] = (nv == '0) ? size_m[sel_grant_res] : nv;
      if (tgt_grp) begin
        nv = skip[GID] & ~cand[GID];
        seq_d[GID] = (nv == '0) ? GRP_SIZE : nv;
      end
    end

    if (u_en && (32'(u_res) < GID)) begin
      nv = avail_q[u_res] & ~u_unit;
      avail_d[u_res] = nv;
      if ((nv == '0) && (avail_q[u_res] != '0)) begin
        bitm = W'(1) << u_res;
        avail_d[GID] = avail_d[GID] & ~bitm;
        base  = seq_d[GID];
        top32 = msb_of(32'(base));
        if (bitm > top32[W-1:0]) def_d[GID] = def_q[GID] | bitm;
        base = base & ~bitm;
        if (base == '0) begin
          seq_d[GID] = GRP_SIZE ^ def_d[GID];
          def_d[GID] = '0;
        end else begin
          seq_d[GID] = base;
        end
      end
    end

    if (rel_valid && (32'(rel_res) < GID)) begin
      avail_d[rel_res] = (avail_q[rel_res] | W'(rel_unit)) & LEAF_SIZE;
      if ((avail_q[rel_res] == '0) && (rel_unit != '0)) begin
        avail_d[GID] = avail_d[GID] | (W'(1) << rel_res);
      end
    end
  end

  // Checker state: last accepted grant
  logic          acc_q;
  logic [RW-1:0] ares_q;
  logic [W-1:0]  aunit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      ares_q  <= '0;
      aunit_q <= '0;
    end else begin
      acc_q   <= accept;
      ares_q  <= sel_grant_res;
      aunit_q <= gunit_w;
    end
  end

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($countones(sel_grant_unit) == 1));

  // R4
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((avail_q[sel_grant_res] & gunit_w) != '0));

  // R4
  used_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> ((avail_q[ares_q] & aunit_q) == '0));

  // R2
  ready_has_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ready |-> (!use_valid && !rel_valid && res_ready[sel_res]));

  // R6
  for (genvar m = 0; m < NUM_RES; m++) begin : g_mirror
    group_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      avail_q[GID][m] == (|avail_q[m]));
  end

endmodule

// File: tb/sim_rr_unit_picker.sv
`timescale 1ns/1ps
module sim_rr_unit_picker;
  localparam int NUM_RES = 3;
  localparam int UNITS   = 4;
  localparam int RW      = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sel_valid;
  logic [RW-1:0]    sel_res;
  logic             sel_ready;
  logic [RW-1:0]    sel_grant_res;
  logic [UNITS-1:0] sel_grant_unit;
  logic             use_valid;
  logic [RW-1:0]    use_res;
  logic [UNITS-1:0] use_unit;
  logic             rel_valid;
  logic [RW-1:0]    rel_res;
  logic [UNITS-1:0] rel_unit;
  logic [NUM_RES:0] res_ready;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  rr_unit_picker #(.NUM_RES(NUM_RES), .UNITS(UNITS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .sel_valid(sel_valid), .sel_res(sel_res), .sel_ready(sel_ready),
    .sel_grant_res(sel_grant_res), .sel_grant_unit(sel_grant_unit),
    .use_valid(use_valid), .use_res(use_res), .use_unit(use_unit),
    .rel_valid(rel_valid), .rel_res(rel_res), .rel_unit(rel_unit),
    .res_ready(res_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sel_valid = 0; sel_res = '0;
    use_valid = 0; use_res = '0; use_unit = '0;
    rel_valid = 0; rel_res = '0; rel_unit = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Select with expected grant; sampled mid-cycle, committed at next edge.
  task automatic sel_exp(input int res, input int eres, input int eunit, input string tag);
    @(negedge clk);
    sel_valid = 1; sel_res = RW'(res);
    #1;
    chk(sel_ready === 1'b1, {tag, " ready"}, int'(sel_ready), 1);
    chk(sel_grant_res === RW'(eres), {tag, " res"}, int'(sel_grant_res), eres);
    chk(sel_grant_unit === UNITS'(eunit), {tag, " unit"}, int'(sel_grant_unit), eunit);
    @(posedge clk); #1;
    sel_valid = 0;
  endtask

  task automatic use_op(input int res, input int unit);
    @(negedge clk);
    use_valid = 1; use_res = RW'(res); use_unit = UNITS'(unit);
    @(posedge clk); #1;
    use_valid = 0;
  endtask

  task automatic rel_op(input int res, input int unit);
    @(negedge clk);
    rel_valid = 1; rel_res = RW'(res); rel_unit = UNITS'(unit);
    @(posedge clk); #1;
    rel_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(res_ready === 4'b1111, "R1 res_ready after reset", int'(res_ready), 4'hF);
    sel_exp(0, 0, 4'b1000, "R1 first grant");
  endtask

  task automatic t_rotate();
    do_reset();
    sel_exp(0, 0, 4'b1000, "R3 rot0");
    sel_exp(0, 0, 4'b0100, "R3 rot1");
    sel_exp(0, 0, 4'b0010, "R3 rot2");
    sel_exp(0, 0, 4'b0001, "R3 rot3");
    @(negedge clk);
    sel_valid = 1; sel_res = 0; #1;
    chk(sel_ready === 1'b0, "R2 R4 leaf exhausted", int'(sel_ready), 0);
    chk(res_ready === 4'b1110, "R6 leaf flag cleared", int'(res_ready), 4'hE);
    sel_valid = 0;
    rel_op(0, 4'b0100);
    chk(res_ready === 4'b1111, "R8 flag restored", int'(res_ready), 4'hF);
    sel_exp(0, 0, 4'b0100, "R3 skip busy candidate");
  endtask

  task automatic t_group();
    do_reset();
    sel_exp(3, 2, 4'b1000, "R5 grp0");
    sel_exp(3, 1, 4'b1000, "R5 grp1");
    sel_exp(3, 0, 4'b1000, "R5 grp2");
    sel_exp(3, 2, 4'b0100, "R5 grp wrap");
  endtask

  task automatic t_release_free();
    do_reset();
    sel_exp(1, 1, 4'b1000, "R8 g0");
    rel_op(1, 4'b1000);
    sel_exp(1, 1, 4'b0100, "R8 g1");
    sel_exp(1, 1, 4'b0010, "R8 g2");
    sel_exp(1, 1, 4'b0001, "R8 g3");
    sel_exp(1, 1, 4'b1000, "R8 released unit granted again");
  endtask

  task automatic t_deferred();
    do_reset();
    sel_exp(3, 2, 4'b1000, "R7 setup");
    use_op(2, 4'b0100); use_op(2, 4'b0010); use_op(2, 4'b0001);
    for (int u = 3; u >= 0; u--) use_op(1, 1 << u);
    for (int u = 3; u >= 0; u--) use_op(0, 1 << u);
    chk(res_ready === 4'b0000, "R6 all busy, group not ready", int'(res_ready), 0);
    rel_op(2, 4'b0001);
    rel_op(1, 4'b0001);
    chk(res_ready === 4'b1110, "R8 group restored", int'(res_ready), 4'hE);
    sel_exp(3, 1, 4'b0001, "R7 reload excludes deferred");
  endtask

  task automatic t_collide();
    do_reset();
    @(negedge clk);
    use_valid = 1; use_res = 0; use_unit = 4'b1000;
    rel_valid = 1; rel_res = 1; rel_unit = 4'b0001;
    sel_valid = 1; sel_res = 0;
    #1;
    chk(sel_ready === 1'b0, "R2 busy port blocks select", int'(sel_ready), 0);
    @(posedge clk); #1;
    use_valid = 0; rel_valid = 0; sel_valid = 0;
    chk(res_ready === 4'b1111, "R9 flags", int'(res_ready), 4'hF);
    sel_exp(0, 0, 4'b1000, "R9 use dropped");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_rotate();
        t_group();
        t_release_free();
        t_deferred();
        t_collide();
      end
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule